// File: doc/BRIEF.md
# Scaled Multi-Operand Fixed-Point Summer

This block adds a series of unsigned fixed-point operands into one output word. Each operand arrives with its own scaling, and the output word has scaling of its own. A start pulse loads the running sum with a precomputed net bias, which is already held in the output format. After that, operands stream in one per cycle. Each operand is multiplied by its adjusted fractional slope, an unsigned 1.15 value that a bypass bit can replace with exactly one. The product is then moved onto the output radix point by a signed shift, rounded by the mode chosen for that operand, and range-checked. The converted value is added to the running sum, and that addition is range-checked again.

Rounding and overflow handling are applied to every operand as it is converted and to every partial sum. The final sum is never rounded as a whole. The result can therefore differ from the ideal real-valued total. In the reference case the operands 19.875 (2^-3), 5.4375 (2^-4) and 4.84375 (2^-5) are summed into an 8-bit output at 2^-3 with floor rounding. The result is 30.0, while the ideal sum is 30.15625.

The operand input is a valid/ready stream. `op_ready` is high from the cycle after `start` until the operand marked `op_last` has been accepted. A beat transfers on any rising edge where both `op_valid` and `op_ready` are high. `op_valid` may be held while `op_ready` is low, and the beat then waits without effect. The result side has no back-pressure. `done` pulses for one cycle, and `result` holds its value until the next `start`.

Top module: `scaled_sum_acc`

## Requirements
- R1: In the cycle after `start`, `result` equals the `net_bias` presented with it, `overflow` is 0 and `op_ready` is 1. `start` takes priority over a beat in the same cycle. After reset, `result` = 0, `overflow` = 0, `op_ready` = 0 and `done` = 0.
- R2: A beat presented while `op_ready` is 0 leaves `result` and `overflow` unchanged. After the beat with `op_last`=1 is accepted, `op_ready` is 0 until the next `start`.
- R3: With `op_slope_en`=1 the operand is scaled by `op_slope`/2^15. With `op_slope_en`=0 the slope is exactly one.
- R4: `op_shift` is a signed two's-complement count equal to the operand's fractional bits minus the output's fractional bits. A positive value shifts the scaled operand right by that many places, and a negative value shifts it left.
- R5: With `op_round`=0 (floor), the bits shifted out below the output LSB are discarded.
- R6: With `op_round`=1 (nearest), one half output LSB is added before the discard, so ties round up.
- R7: If a converted operand exceeds 2^OUT_W-1, `op_sat`=1 clamps it to 2^OUT_W-1 and `op_sat`=0 keeps its low OUT_W bits. In both cases `overflow` is set.
- R8: If adding the converted operand to the running sum carries out of OUT_W bits, `op_sat`=1 clamps the sum to 2^OUT_W-1 and `op_sat`=0 wraps it modulo 2^OUT_W. In both cases `overflow` is set.
- R9: `overflow` is sticky. Once set, it stays at 1 until the next `start`.
- R10: `done` is high for exactly one cycle, the cycle after the `op_last` beat is accepted. At that point `result` holds the final sum.
- R11: Rounding is applied per operand. For OUT_W=8 with bias 0 and floor rounding, operands 159, 87 and 155 with shifts 0, 1 and 2 give 240. With nearest rounding the same operands give 242.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new sum; loads the net bias |
| net_bias | input | OUT_W | Initial sum in output format |
| op_valid | input | 1 | Operand beat valid |
| op_ready | output | 1 | Summer accepts an operand |
| op_data | input | IN_W | Operand stored integer, unsigned |
| op_slope | input | SLOPE_W | Adjusted fractional slope, unsigned 1.15 |
| op_slope_en | input | 1 | 1: apply op_slope; 0: slope is one |
| op_shift | input | SHIFT_W | Signed radix alignment, operand minus output fraction bits |
| op_round | input | 1 | 0: floor; 1: round to nearest |
| op_sat | input | 1 | 0: wrap on overflow; 1: saturate |
| op_last | input | 1 | Marks the final operand of the sum |
| done | output | 1 | One-cycle pulse after the last operand |
| result | output | OUT_W | Running or final sum |
| overflow | output | 1 | Sticky overflow flag for the current sum |

## Verification
The assertions watch the control skeleton on every cycle. They check that the bias loads on `start` and that the sum holds between accepted beats. They also check the single-cycle `done` after the last beat, that `op_ready` drops when the sum closes, and that a saturating beat never lowers the sum and pins it to full scale when its conversion overflows. The arithmetic values cannot be shown by these properties. The exact products for a given slope, the rounding direction for a given shift and the wrap residue all come from the bench's scenarios, which compare against an independent integer model. The per-operand rounding loss is one of these, shown by the reference sum of 240 where a single final rounding would give 241.

// File: rtl/ssum_pkg.sv
package ssum_pkg;
  typedef enum logic { RND_FLOOR = 1'b0, RND_NEAR = 1'b1 } rnd_mode_e;
  typedef enum logic { OVF_WRAP = 1'b0, OVF_SAT = 1'b1 } ovf_mode_e;

  typedef struct packed {
    logic add_en;
    logic load;
    logic last;
  } ssum_ctl_t;
endpackage

// File: rtl/ssum_ctrl.sv
module ssum_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_valid,
  input  logic op_last,
  output logic busy,
  output logic accept,
  output logic done
);
  assign accept = op_valid && busy && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
      end else if (accept && op_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_last) |=> done);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_last) |=> !busy);
  assert_ready_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/ssum_align.sv
module ssum_align #(
  parameter int IN_W     = 8,
  parameter int SLOPE_W  = 16,
  parameter int SHIFT_W  = 5,
  parameter int OUT_W    = 8,
  parameter bit USE_MULT = 1'b1
) (
  input  logic [IN_W-1:0]    data,
  input  logic [SLOPE_W-1:0] slope,
  input  logic               slope_en,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               round_near,
  input  logic               sat,
  output logic [OUT_W-1:0]   conv,
  output logic               conv_ovf
);
  localparam int SLOPE_FRAC = SLOPE_W - 1;
  localparam int PROD_W     = IN_W + SLOPE_W;
  localparam int EXT        = 2 ** (SHIFT_W - 1);
  localparam int WIDE_W     = PROD_W + EXT;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] unity;

  assign unity = PROD_W'(data) << SLOPE_FRAC;

  generate
    if (USE_MULT) begin : g_mult
      assign prod = slope_en ? (PROD_W'(data) * PROD_W'(slope)) : unity;
    end else begin : g_nomult
      assign prod = unity;
    end
  endgenerate

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] int_part;
  logic [WIDE_W-1:0] half_vec;
  logic [WIDE_W:0]   rounded;
  int                k;

  always_comb begin
    wide     = {prod, {EXT{1'b0}}};
    k        = EXT + SLOPE_FRAC + int'($signed(shift));
    int_part = wide >> k;
    half_vec = wide >> (k - 1);
    rounded  = {1'b0, int_part} + (WIDE_W+1)'(round_near & half_vec[0]);
    conv_ovf = |rounded[WIDE_W:OUT_W];
    if (conv_ovf && sat) conv = {OUT_W{1'b1}};
    else                 conv = rounded[OUT_W-1:0];
  end
endmodule

// File: rtl/ssum_accum.sv
module ssum_accum #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] bias,
  input  logic             add_en,
  input  logic [OUT_W-1:0] addend,
  input  logic             sat,
  input  logic             conv_ovf,
  output logic [OUT_W-1:0] acc,
  output logic             ovf
);
  logic [OUT_W:0] sum;
  logic           carry;

  assign sum   = {1'b0, acc} + {1'b0, addend};
  assign carry = sum[OUT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (load) begin
      acc <= bias;
      ovf <= 1'b0;
    end else if (add_en) begin
      acc <= (carry && sat) ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
      ovf <= ovf | carry | conv_ovf;
    end
  end

  assert_bias_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc == $past(bias)) && !ovf);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !add_en) |=> $stable(acc) && $stable(ovf));
  assert_sat_no_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && add_en && sat) |=> acc >= $past(acc));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !load) |=> ovf);
endmodule

// File: rtl/scaled_sum_acc.sv
module scaled_sum_acc #(
  parameter int IN_W     = 8,
  parameter int SLOPE_W  = 16,
  parameter int SHIFT_W  = 5,
  parameter int OUT_W    = 8,
  parameter bit USE_MULT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [OUT_W-1:0]   net_bias,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic [IN_W-1:0]    op_data,
  input  logic [SLOPE_W-1:0] op_slope,
  input  logic               op_slope_en,
  input  logic [SHIFT_W-1:0] op_shift,
  input  logic               op_round,
  input  logic               op_sat,
  input  logic               op_last,
  output logic               done,
  output logic [OUT_W-1:0]   result,
  output logic               overflow
);
  import ssum_pkg::*;

  ssum_ctl_t        ctl;
  logic             busy;
  logic             accept;
  logic [OUT_W-1:0] conv;
  logic             conv_ovf;

  ssum_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .op_last  (op_last),
    .busy     (busy),
    .accept   (accept),
    .done     (done)
  );

  assign ctl.load   = start;
  assign ctl.add_en = accept;
  assign ctl.last   = op_last;
  assign op_ready   = busy;

  ssum_align #(
    .IN_W(IN_W), .SLOPE_W(SLOPE_W), .SHIFT_W(SHIFT_W),
    .OUT_W(OUT_W), .USE_MULT(USE_MULT)
  ) u_align (
    .data       (op_data),
    .slope      (op_slope),
    .slope_en   (op_slope_en),
    .shift      (op_shift),
    .round_near (op_round == RND_NEAR),
    .sat        (op_sat == OVF_SAT),
    .conv       (conv),
    .conv_ovf   (conv_ovf)
  );

  ssum_accum #(.OUT_W(OUT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load),
    .bias     (net_bias),
    .add_en   (ctl.add_en),
    .addend   (conv),
    .sat      (op_sat == OVF_SAT),
    .conv_ovf (conv_ovf),
    .acc      (result),
    .ovf      (overflow)
  );

  assert_conv_sat_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_sat && conv_ovf) |=> (result == {OUT_W{1'b1}}) && overflow);
  assert_conv_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && conv_ovf) |=> overflow);
  assert_last_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ctl.last) |=> (done && !op_ready));
endmodule

// File: tb/test_scaled_sum_acc.sv
module test_scaled_sum_acc;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8, SLOPE_W = 16, SHIFT_W = 5, OUT_W = 8;
  localparam longint MAXV = (64'd1 << OUT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [OUT_W-1:0] net_bias = '0;
  logic op_valid = 1'b0, op_slope_en = 1'b0, op_round = 1'b0, op_sat = 1'b0, op_last = 1'b0;
  logic [IN_W-1:0] op_data = '0;
  logic [SLOPE_W-1:0] op_slope = '0;
  logic [SHIFT_W-1:0] op_shift = '0;
  logic op_ready, done, overflow;
  logic [OUT_W-1:0] result;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_sum_acc i_scaled_sum_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .net_bias(net_bias),
    .op_valid(op_valid), .op_ready(op_ready), .op_data(op_data),
    .op_slope(op_slope), .op_slope_en(op_slope_en), .op_shift(op_shift),
    .op_round(op_round), .op_sat(op_sat), .op_last(op_last),
    .done(done), .result(result), .overflow(overflow)
  );

  // Behavioural reference model
  longint m_acc = 0;
  bit m_busy = 0, m_done = 0, m_ovf = 0;

  function automatic longint conv_ref(longint d, longint s, bit s_en, int sh,
                                      bit near, bit sat, output bit ov);
    longint num = d * (s_en ? s : 32768);
    int e = 15 + sh;
    longint q;
    if (e > 0) q = near ? ((num + (64'sd1 <<< (e-1))) >>> e) : (num >>> e);
    else       q = num <<< (-e);
    ov = (q > MAXV);
    if (ov) q = sat ? MAXV : (q % (MAXV + 1));
    return q;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc <= 0; m_busy <= 0; m_done <= 0; m_ovf <= 0;
    end else if (start) begin
      m_acc <= net_bias; m_busy <= 1; m_ovf <= 0; m_done <= 0;
    end else begin
      m_done <= 0;
      if (op_valid && m_busy) begin
        bit cov;
        longint c, s;
        c = conv_ref(op_data, op_slope, op_slope_en, int'($signed(op_shift)),
                     op_round, op_sat, cov);
        s = m_acc + c;
        if (s > MAXV) begin
          s = op_sat ? MAXV : (s - MAXV - 1);
          cov = 1;
        end
        m_acc <= s;
        m_ovf <= m_ovf | cov;
        if (op_last) begin m_busy <= 0; m_done <= 1; end
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " result"}, result, m_acc);
      chk({cur_req, " overflow"}, overflow, m_ovf);
      chk("R10 done", done, m_done);
      chk("R2 op_ready", op_ready, m_busy);
    end
  end

  task automatic do_start(int bias);
    start = 1; net_bias = OUT_W'(bias);
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(int d, int s, bit s_en, int sh, bit near, bit sat, bit last);
    op_valid = 1; op_data = IN_W'(d); op_slope = SLOPE_W'(s); op_slope_en = s_en;
    op_shift = SHIFT_W'(sh); op_round = near; op_sat = sat; op_last = last;
    @(negedge clk);
    op_valid = 0; op_last = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset result", result, 0);
    chk("R1 reset ready", op_ready, 0);
    chk("R10 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);

    // R11 and R5: reference sum, floor rounding
    cur_req = "R11";
    do_start(0);
    chk("R1 ready after start", op_ready, 1);
    send(159, 0, 0, 0, 0, 1, 0);
    send(87, 0, 0, 1, 0, 1, 0);
    send(155, 0, 0, 2, 0, 1, 1);
    chk("R10 done after last", done, 1);
    chk("R11 floor sum", result, 240);
    chk("R2 ready low after last", op_ready, 0);
    @(negedge clk);
    chk("R10 done single", done, 0);

    // R6: nearest rounding
    cur_req = "R6";
    do_start(0);
    send(159, 0, 0, 0, 1, 1, 0);
    send(87, 0, 0, 1, 1, 1, 0);
    send(155, 0, 0, 2, 1, 1, 1);
    chk("R6 nearest sum", result, 242);

    // R3: slope multiply with bias
    cur_req = "R3";
    do_start(10);
    chk("R1 bias loaded", result, 10);
    send(100, 16'h6000, 1, 0, 0, 1, 0);
    chk("R3 slope 0.75", result, 85);
    send(3, 16'h4000, 1, 0, 0, 1, 0);
    chk("R5 floor 1.5", result, 86);
    send(3, 16'h4000, 1, 0, 1, 1, 1);
    chk("R6 nearest 1.5", result, 88);

    // R4 and R7: left shift and conversion overflow
    cur_req = "R7";
    do_start(0);
    send(5, 0, 0, -2, 0, 1, 0);
    chk("R4 left shift", result, 20);
    chk("R7 no ovf yet", overflow, 0);
    send(70, 0, 0, -2, 0, 0, 0);
    chk("R7 wrap conv", result, 44);
    chk("R7 ovf set", overflow, 1);
    send(70, 0, 0, -2, 0, 1, 1);
    chk("R7 sat conv", result, 255);

    // R8 and R9: sum overflow, sticky flag
    cur_req = "R8";
    do_start(200);
    chk("R9 cleared by start", overflow, 0);
    send(100, 0, 0, 0, 0, 0, 0);
    chk("R8 wrap sum", result, 44);
    chk("R8 ovf set", overflow, 1);
    send(1, 0, 0, 0, 0, 0, 0);
    chk("R9 sticky", overflow, 1);
    send(250, 0, 0, 0, 0, 1, 1);
    chk("R8 sat sum", result, 255);

    // R2: beats while not ready are ignored
    cur_req = "R2";
    send(50, 0, 0, 0, 0, 1, 0);
    send(9, 0, 0, -1, 0, 0, 1);
    chk("R2 ignored result", result, 255);
    chk("R2 ignored done", done, 0);
    do_start(1);
    @(negedge clk);
    send(4, 0, 0, 0, 0, 1, 0);
    start = 1; net_bias = 7; op_valid = 1; op_data = 9; op_last = 1;
    @(negedge clk);
    start = 0; op_valid = 0; op_last = 0;
    chk("R1 start wins", result, 7);

    // Mixed random sums against the model
    cur_req = "R3";
    for (int t = 0; t < 40; t++) begin
      do_start($urandom_range(0, 40));
      for (int j = 0; j < 4; j++) begin
        if ($urandom_range(0, 2) == 0) @(negedge clk);
        send($urandom_range(0, 255), $urandom_range(0, 65535), $urandom_range(0, 1),
             int'($urandom_range(0, 9)) - 3, $urandom_range(0, 1),
             $urandom_range(0, 1), j == 3);
      end
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule